// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This block is the arithmetic and logic datapath of a small accumulator machine. Each cycle it takes the accumulator byte, a second operand byte and an operation code. It returns a result byte, a strobe that says whether the result should be written back to the accumulator, and the next value of the four condition flags. The flags are zero, subtract, half-carry and carry.

The flag register is kept inside the block. It feeds the carry into add-with-carry, subtract-with-borrow and rotate, and it supplies the values that an operation leaves untouched. It loads the computed flags on a rising clock edge while `flag_we_i` is high. Compare and bit test change only the flags, so the write-back strobe is low for them.

Operation codes are four bits wide. When bit 3 is set the code is a bit test, and bits 2:0 give the index of the tested bit. When bit 3 is clear, bits 2:0 select one of the following:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | add with carry |
| 2 | subtract |
| 3 | subtract with borrow |
| 4 | exclusive-or |
| 5 | compare |
| 6 | rotate left through carry |
| 7 | hold |

There is no sequencing: the result path is purely combinational. The only state is the flag register, which has two states, reset-clear and loaded.

Top module: `alu8_flags`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four bits of `flags_o` to 0.
- R2: `res_we_o` is 1 for codes 0, 1, 2, 3, 4 and 6, and 0 for code 5, code 7 and every code with bit 3 set.
- R3: Code 0 (add) and code 1 (add with carry) give result = (acc + operand + cin) mod 256. For code 1, cin is the stored C flag; for code 0, cin is 0. The flags become: N = 0; Z = 1 when the result is 0; H = carry out of bit 3; C = carry out of bit 7.
- R4: Code 2 (subtract) and code 3 (subtract with borrow) give result = (acc − operand − cin) mod 256. For code 3, cin is the stored C flag; for code 2, cin is 0. The flags become: N = 1; Z = 1 when the result is 0; H = borrow from bit 4, meaning the low nibble of acc is smaller than the low nibble of the operand plus cin; C = borrow, meaning acc < operand + cin.
- R5: Code 5 (compare) leaves `res_o` equal to the accumulator and sets N = 1, Z = (acc == operand), C = (acc < operand), and H = (low nibble of acc < low nibble of operand).
- R6: Code 4 (exclusive-or) gives result = acc XOR operand, sets Z = 1 exactly when the result is 0, and clears N, H and C.
- R7: Code 6 (rotate left through carry) gives result = {acc[6:0], stored C}, sets the new C to the old acc[7], and clears Z, N and H.
- R8: A code with bit 3 set tests operand bit op[2:0]. It sets Z to the inverse of that bit, clears N, sets H, leaves C at its stored value, and keeps `res_o` equal to the accumulator.
- R9: Code 7 (hold) drives `nxt_flags_o` equal to `flags_o` and `res_o` equal to the accumulator.
- R10: `flags_o` is ordered {Z, N, H, C} from bit 3 down to bit 0. It takes the value of `nxt_flags_o` at a rising edge where `flag_we_i` is 1, and holds its value when `flag_we_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_i | input | 8 | Accumulator byte |
| opnd_i | input | 8 | Second operand byte |
| op_i | input | 4 | Operation code |
| flag_we_i | input | 1 | Load the computed flags at the next rising edge |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result is to be written to the accumulator |
| nxt_flags_o | output | 4 | Computed flags {Z,N,H,C} |
| flags_o | output | 4 | Registered flags {Z,N,H,C} |

## Verification
The properties assume the following about the inputs:
- `op_i`, `acc_i`, `opnd_i` and `flag_we_i` always carry defined values.
- These inputs change only between rising edges.
- The same `op_i` value is seen by the combinational outputs and by the register load in the same cycle.

The stimulus keeps within these assumptions. It drives every input on the falling edge, holds reset from time zero, and uses only four-bit codes, all of which are defined. For each operation code it presets the carry to 0 and then to 1 through a real flag load. It then sweeps the accumulator over every third value from 0 to 255 and the operand over steps of 15 plus the diagonal, so that equal, lower and higher operands and nibble borrows all occur.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int OP_W    = IDX_W + 1;
    localparam int FLAG_W  = 4;

    typedef logic [IDX_W-1:0] code_t;

    localparam code_t C_ADD  = code_t'(0);
    localparam code_t C_ADC  = code_t'(1);
    localparam code_t C_SUB  = code_t'(2);
    localparam code_t C_SBC  = code_t'(3);
    localparam code_t C_XOR  = code_t'(4);
    localparam code_t C_CMP  = code_t'(5);
    localparam code_t C_RLC  = code_t'(6);
    localparam code_t C_HOLD = code_t'(7);

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hout_o
);
    logic [W:0]   full;
    logic [NIB:0] nib;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            nib  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            nib  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        end
    end

    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
    assign hout_o = nib[NIB];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic             cin_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [W-1:0]     xor_o,
    output logic [W-1:0]     rot_o,
    output logic             rot_cout_o,
    output logic             bit_zero_o
);
    assign xor_o      = a_i ^ b_i;
    assign rot_o      = {a_i[W-2:0], cin_i};
    assign rot_cout_o = a_i[W-1];
    assign bit_zero_o = ~b_i[idx_i];
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we_i,
    input  flags_t d_i,
    output flags_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (we_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int OPW = OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   acc_i,
    input  logic [DW-1:0]   opnd_i,
    input  logic [OPW-1:0]  op_i,
    input  logic            flag_we_i,
    output logic [DW-1:0]   res_o,
    output logic            res_we_o,
    output logic [FLAG_W-1:0] nxt_flags_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int IW = OPW - 1;

    flags_t        cur_q;
    flags_t        nxt;
    logic          is_bit;
    logic [IW-1:0] code;
    logic          sub_sel;
    logic          cin_sel;
    logic [DW-1:0] sum;
    logic          sum_c;
    logic          sum_h;
    logic [DW-1:0] xr;
    logic [DW-1:0] rot;
    logic          rot_c;
    logic          bz;

    assign is_bit  = op_i[OPW-1];
    assign code    = op_i[IW-1:0];
    assign sub_sel = !is_bit && (code == C_SUB || code == C_SBC || code == C_CMP);
    assign cin_sel = !is_bit && (code == C_ADC || code == C_SBC) && cur_q.c;

    alu8_arith #(.W(DW), .NIB(NIB_W)) i_arith (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .cin_i  (cin_sel),
        .sub_i  (sub_sel),
        .sum_o  (sum),
        .cout_o (sum_c),
        .hout_o (sum_h)
    );

    alu8_logic #(.W(DW), .IDX_W(IW)) i_logic (
        .a_i        (acc_i),
        .b_i        (opnd_i),
        .cin_i      (cur_q.c),
        .idx_i      (code),
        .xor_o      (xr),
        .rot_o      (rot),
        .rot_cout_o (rot_c),
        .bit_zero_o (bz)
    );

    always_comb begin
        res_o    = acc_i;
        res_we_o = 1'b0;
        nxt      = cur_q;
        if (is_bit) begin
            nxt.z = bz;
            nxt.n = 1'b0;
            nxt.h = 1'b1;
        end else begin
            unique case (code)
                C_ADD, C_ADC: begin
                    res_o    = sum;
                    res_we_o = 1'b1;
                    nxt      = '{z: (sum == '0), n: 1'b0, h: sum_h, c: sum_c};
                end
                C_SUB, C_SBC: begin
                    res_o    = sum;
                    res_we_o = 1'b1;
                    nxt      = '{z: (sum == '0), n: 1'b1, h: sum_h, c: sum_c};
                end
                C_XOR: begin
                    res_o    = xr;
                    res_we_o = 1'b1;
                    nxt      = '{z: (xr == '0), n: 1'b0, h: 1'b0, c: 1'b0};
                end
                C_CMP: begin
                    nxt = '{z: (sum == '0), n: 1'b1, h: sum_h, c: sum_c};
                end
                C_RLC: begin
                    res_o    = rot;
                    res_we_o = 1'b1;
                    nxt      = '{z: 1'b0, n: 1'b0, h: 1'b0, c: rot_c};
                end
                default: begin
                    nxt = cur_q;
                end
            endcase
        end
    end

    alu8_flagreg i_flagreg (
        .clk  (clk),
        .rst  (rst),
        .we_i (flag_we_i),
        .d_i  (nxt),
        .q_o  (cur_q)
    );

    assign nxt_flags_o = nxt;
    assign flags_o     = cur_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int OPW = OP_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DW-1:0]     acc_i,
    input logic [OPW-1:0]    op_i,
    input logic              flag_we_i,
    input logic [DW-1:0]     res_o,
    input logic              res_we_o,
    input logic [FLAG_W-1:0] nxt_flags_o,
    input logic [FLAG_W-1:0] flags_o
);
    localparam logic [OPW-1:0] K_SUB  = OPW'(2);
    localparam logic [OPW-1:0] K_SBC  = OPW'(3);
    localparam logic [OPW-1:0] K_XOR  = OPW'(4);
    localparam logic [OPW-1:0] K_CMP  = OPW'(5);
    localparam logic [OPW-1:0] K_HOLD = OPW'(7);

    p_keep_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (!flag_we_i) |=> $stable(flags_o));

    p_load_flags_r10: assert property (@(posedge clk) disable iff (rst)
        flag_we_i |=> (flags_o == $past(nxt_flags_o)));

    p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == K_CMP) |-> (!res_we_o && res_o == acc_i && nxt_flags_o[2]));

    p_sub_sets_n_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == K_SUB || op_i == K_SBC) |-> (nxt_flags_o[2] && res_we_o));

    p_xor_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == K_XOR) |-> (nxt_flags_o[2:0] == 3'b000 && nxt_flags_o[3] == (res_o == '0)));

    p_bit_keeps_c_r8: assert property (@(posedge clk) disable iff (rst)
        op_i[OPW-1] |-> (nxt_flags_o[0] == flags_o[0] && !res_we_o && res_o == acc_i));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == K_HOLD) |-> (nxt_flags_o == flags_o && !res_we_o));
endmodule

bind alu8_flags alu8_flags_chk #(.DW(DW), .OPW(OPW)) i_alu8_flags_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_i       (acc_i),
    .op_i        (op_i),
    .flag_we_i   (flag_we_i),
    .res_o       (res_o),
    .res_we_o    (res_we_o),
    .nxt_flags_o (nxt_flags_o),
    .flags_o     (flags_o)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic [3:0] op = '0;
    logic       fwe = 1'b0;
    logic [7:0] res;
    logic       rwe;
    logic [3:0] nfl;
    logic [3:0] fl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_flags i_alu8_flags (
        .clk         (clk),
        .rst         (rst),
        .acc_i       (acc),
        .opnd_i      (opnd),
        .op_i        (op),
        .flag_we_i   (fwe),
        .res_o       (res),
        .res_we_o    (rwe),
        .nxt_flags_o (nfl),
        .flags_o     (fl)
    );

    function automatic string tag_of(input int code);
        if (code >= 8) return "R8";
        case (code)
            0, 1: return "R3";
            2, 3: return "R4";
            4: return "R6";
            5: return "R5";
            6: return "R7";
            default: return "R9";
        endcase
    endfunction

    // returns {we, result[7:0], flags[3:0]} with flags ordered Z N H C
    function automatic logic [12:0] model(input int code, input int a, input int b, input logic [3:0] f);
        int cin, s, lo, r;
        logic z, n, h, c, we;
        cin = f[0] ? 1 : 0;
        r = a; z = f[3]; n = f[2]; h = f[1]; c = f[0]; we = 0;
        if (code >= 8) begin
            z = ((b >> (code - 8)) % 2) == 0; n = 0; h = 1;
        end else if (code == 0 || code == 1) begin
            if (code == 0) cin = 0;
            s = a + b + cin; r = s % 256;
            lo = (a % 16) + (b % 16) + cin;
            z = (r == 0); n = 0; h = (lo > 15); c = (s > 255); we = 1;
        end else if (code == 2 || code == 3 || code == 5) begin
            if (code != 3) cin = 0;
            s = a - b - cin;
            lo = (a % 16) - (b % 16) - cin;
            z = (((s + 256) % 256) == 0); n = 1; h = (lo < 0); c = (s < 0);
            if (code != 5) begin r = (s + 256) % 256; we = 1; end
        end else if (code == 4) begin
            r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; we = 1;
        end else if (code == 6) begin
            r = ((a * 2) % 256) + cin; c = (a >= 128); z = 0; n = 0; h = 0; we = 1;
        end
        return {we, 8'(r), z, n, h, c};
    endfunction

    task automatic note(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%0d acc=%02h opnd=%02h actual=%0h expected=%0h", tag, op, acc, opnd, got, exp);
        end
    endtask

    // set stored flags through a real flag load (R10)
    task automatic preset(input bit carry, output logic [3:0] f);
        @(negedge clk);
        op = 4'd0; acc = carry ? 8'hFF : 8'h00; opnd = carry ? 8'h01 : 8'h00; fwe = 1'b1;
        @(negedge clk);
        fwe = 1'b0;
        f = carry ? 4'b1011 : 4'b1000;
        note(fl == f, "R10", fl, f);
    endtask

    initial begin
        logic [3:0] pf;
        logic [12:0] e;
        repeat (3) @(negedge clk);
        // R1: reset state
        note(fl == 4'b0000, "R1", fl, 0);
        rst = 1'b0;

        // R10: hold while write enable low
        @(negedge clk);
        op = 4'd2; acc = 8'h00; opnd = 8'h01; fwe = 1'b0;
        @(negedge clk);
        note(fl == 4'b0000, "R10", fl, 0);
        fwe = 1'b1;
        @(negedge clk);
        fwe = 1'b0;
        note(fl == 4'b0111, "R10", fl, 4'b0111);

        // R1: reset clears a loaded register
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        note(fl == 4'b0000, "R1", fl, 0);

        for (int code = 0; code < 16; code++) begin
            for (int cs = 0; cs < 2; cs++) begin
                preset(cs[0], pf);
                for (int a = 0; a < 256; a += 3) begin
                    for (int bi = 0; bi < 19; bi++) begin
                        int b;
                        b = (bi < 18) ? bi * 15 : a;
                        @(negedge clk);
                        op = 4'(code); acc = 8'(a); opnd = 8'(b);
                        #1;
                        e = model(code, a, b, pf);
                        note(res == e[11:4] && nfl == e[3:0], tag_of(code),
                             {res, nfl}, e[11:0]);
                        // R2: write-back strobe per code
                        if (rwe !== e[12]) note(1'b0, "R2", rwe, e[12]);
                    end
                end
                note(fl == pf, "R10", fl, pf);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule